// File: doc/BRIEF.md
# Video Field Description Registers

This block holds the description of the current video field that a filtering core works from: active width, active height, interlace nibble, chroma co-siting, colour space code, chroma subsampling code and field counter. A parameter selects one of two modes. In software-set mode, a host writes the expected width, height, interlace nibble and co-siting over a 32-bit word-addressed register bus. In packet-driven mode, an upstream parser hands over the values it has extracted from an image-information control packet, with a single strobe. The block captures every field in the same cycle. It stores the dimensions with one added, because the packet carries them as value minus one.

A second parameter enables debug read access. In software-set mode the registers are write-only unless debug is on. In packet-driven mode the bus cannot write them, and they are readable only when debug is on. A status word reports whether the core is busy on a field, and whether it is idle so that coefficients can be changed safely. The status word is readable in every configuration. The captured values also drive dedicated configuration outputs for the core. These include a flag that allows the odd/even field sideband bit to pass through.

Top module: `field_info_regs`

## Requirements
- R1: After reset every stored field, every configuration output, `rdata_o` and `rvalid_o` are zero.
- R2: In software-set mode a write to byte offset 0x120 sets width and a write to 0x124 sets height, taking `wdata_i[15:0]`. The value appears on the configuration output after the write edge. With debug on, a read returns it in bits 15:0 with bits 31:16 zero.
- R3: In software-set mode, offset 0x128 takes the interlace nibble from `wdata_i[3:0]` and offset 0x138 takes co-siting from `wdata_i[1:0]`. Interlace bit 3 drives `field_flag_en_o`: 1 allows the odd/even field flag to pass, 0 blocks it.
- R4: In software-set mode, colour space (0x130), subsampling (0x134) and field count (0x13C) have no function. Writes to them are ignored, and their reads and configuration outputs stay zero.
- R5: In software-set mode with debug off, the registers are write-only. Reads of every field offset return zero, while writes still update the configuration outputs.
- R6: In packet-driven mode, one cycle of `pkt_valid_i` captures all seven fields together on that edge. Width and height are stored as the input plus one, modulo 2^16, so an input of 0xFFFF gives 0. Software-set mode ignores the packet inputs.
- R7: In packet-driven mode, bus writes change no stored field.
- R8: In packet-driven mode, reads return the colour space (bits 6:0), subsampling (bits 1:0), co-siting (bits 1:0) and field count (bits 6:0) only when debug is on. With debug off, every field offset reads zero, while the configuration outputs still follow the captured packet.
- R9: Offset 0x140 reads `core_busy_i` in bit 0 and `core_idle_i` in bit 2, sampled on the read edge, with all other bits zero. It does so in every mode.
- R10: Unmapped offsets read zero and ignore writes. These include the reserved 0x12C and any address with bits 1:0 non-zero.
- R11: `rvalid_o` is high for exactly the cycle after each cycle with `rd_en_i` high. `rdata_o` holds the read result in that cycle and zero otherwise.
- R12: In packet-driven mode the stored fields hold their values while `pkt_valid_i` is low, whatever the packet inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after rd_en_i |
| rvalid_o | output | 1 | Read data valid |
| pkt_valid_i | input | 1 | Packet field strobe |
| pkt_width_m1_i | input | 16 | Packet width minus one |
| pkt_height_m1_i | input | 16 | Packet height minus one |
| pkt_interlace_i | input | 4 | Packet interlace nibble |
| pkt_colorspace_i | input | 7 | Packet colour space code |
| pkt_subsample_i | input | 2 | Packet subsampling code |
| pkt_cosite_i | input | 2 | Packet co-siting code |
| pkt_field_count_i | input | 7 | Packet field counter |
| core_busy_i | input | 1 | Core is processing a field |
| core_idle_i | input | 1 | Core idle, coefficients may change |
| cfg_width_o | output | 16 | Current width |
| cfg_height_o | output | 16 | Current height |
| cfg_interlace_o | output | 4 | Current interlace nibble |
| cfg_colorspace_o | output | 7 | Current colour space code |
| cfg_subsample_o | output | 2 | Current subsampling code |
| cfg_cosite_o | output | 2 | Current co-siting code |
| cfg_field_count_o | output | 7 | Current field counter |
| field_flag_en_o | output | 1 | Pass the odd/even field flag |

## Verification
The bench builds four instances on shared stimulus. They cover software-set mode with and without debug, and packet-driven mode with and without debug. The same bus write therefore shows at once in every configuration, whether it lands, is ignored or stays write-only. Dimension wrap at 0xFFFF, misaligned and reserved offsets, and packet inputs that change without a strobe are driven directly. The status word is compared across all four instances.

// File: rtl/field_info_pkg.sv
package field_info_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned DIM_W  = 16;
  localparam int unsigned INTL_W = 4;
  localparam int unsigned CSP_W  = 7;
  localparam int unsigned SUBS_W = 2;
  localparam int unsigned COS_W  = 2;
  localparam int unsigned FCNT_W = 7;

  localparam int unsigned FLAG_BIT      = INTL_W - 1;
  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_IDLE_BIT = 2;

  typedef enum logic [2:0] {
    REG_WIDTH  = 3'd0,
    REG_HEIGHT = 3'd1,
    REG_INTL   = 3'd2,
    REG_CSP    = 3'd3,
    REG_SUBS   = 3'd4,
    REG_COSITE = 3'd5,
    REG_FCNT   = 3'd6,
    REG_STATUS = 3'd7
  } reg_idx_e;

  localparam int unsigned NUM_REGS = 8;

  typedef struct packed {
    logic [DIM_W-1:0]  width;
    logic [DIM_W-1:0]  height;
    logic [INTL_W-1:0] intl;
    logic [CSP_W-1:0]  csp;
    logic [SUBS_W-1:0] subs;
    logic [COS_W-1:0]  cosite;
    logic [FCNT_W-1:0] fcnt;
  } field_info_t;

  function automatic int unsigned reg_offset(input int unsigned idx);
    case (idx)
      0:       return 32'h120;
      1:       return 32'h124;
      2:       return 32'h128;
      3:       return 32'h130;
      4:       return 32'h134;
      5:       return 32'h138;
      6:       return 32'h13C;
      default: return 32'h140;
    endcase
  endfunction

  // fields the bus may set in software-set mode
  function automatic logic lite_field(input int unsigned idx);
    return idx == 0 || idx == 1 || idx == 2 || idx == 5;
  endfunction
endpackage

// File: rtl/field_info_decode.sv
module field_info_decode
  import field_info_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o,
  output logic                hit_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(reg_offset(i));
    assign sel_o[i] = (addr_i == OFS);
  end

  assign hit_o = |sel_o;
endmodule

// File: rtl/field_info_store.sv
module field_info_store
  import field_info_pkg::*;
#(
  parameter bit LITE_MODE = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [NUM_REGS-1:0] sel_i,
  input  logic [BUS_W-1:0]    wdata_i,
  input  logic                pkt_valid_i,
  input  field_info_t         pkt_i,
  output field_info_t         info_o
);
  field_info_t info_q;

  if (LITE_MODE) begin : g_lite
    logic unused_pkt;
    assign unused_pkt = ^{pkt_valid_i, pkt_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        info_q <= '0;
      end else if (wr_en_i) begin
        if (sel_i[REG_WIDTH])  info_q.width  <= wdata_i[DIM_W-1:0];
        if (sel_i[REG_HEIGHT]) info_q.height <= wdata_i[DIM_W-1:0];
        if (sel_i[REG_INTL])   info_q.intl   <= wdata_i[INTL_W-1:0];
        if (sel_i[REG_COSITE]) info_q.cosite <= wdata_i[COS_W-1:0];
      end
    end

    p_lite_hold_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(info_q));
    p_lite_unused_zero_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> (info_q.csp == '0 && info_q.subs == '0 && info_q.fcnt == '0));
  end else begin : g_full
    logic unused_bus;
    assign unused_bus = ^{wr_en_i, sel_i, wdata_i};

    // packet carries dimensions minus one; keep the true size
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        info_q <= '0;
      end else if (pkt_valid_i) begin
        info_q        <= pkt_i;
        info_q.width  <= pkt_i.width + DIM_W'(1);
        info_q.height <= pkt_i.height + DIM_W'(1);
      end
    end

    p_full_hold_r12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pkt_valid_i |=> $stable(info_q));
    p_full_capture_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      pkt_valid_i |=> (info_q.height == $past(pkt_i.height) + DIM_W'(1)
                       && info_q.fcnt == $past(pkt_i.fcnt)));
  end

  assign info_o = info_q;
endmodule

// File: rtl/field_info_rdmux.sv
module field_info_rdmux
  import field_info_pkg::*;
#(
  parameter bit LITE_MODE = 1'b1,
  parameter bit DEBUG_EN  = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_en_i,
  input  logic [NUM_REGS-1:0] sel_i,
  input  logic                hit_i,
  input  field_info_t         info_i,
  input  logic                busy_i,
  input  logic                idle_i,
  output logic [BUS_W-1:0]    rdata_o,
  output logic                rvalid_o
);
  logic [BUS_W-1:0] word [NUM_REGS];
  logic [BUS_W-1:0] masked [NUM_REGS];
  logic [BUS_W-1:0] rd_word;
  logic [BUS_W-1:0] rdata_q;
  logic             rvalid_q;

  always_comb begin
    word[REG_WIDTH]  = BUS_W'(info_i.width);
    word[REG_HEIGHT] = BUS_W'(info_i.height);
    word[REG_INTL]   = BUS_W'(info_i.intl);
    word[REG_CSP]    = BUS_W'(info_i.csp);
    word[REG_SUBS]   = BUS_W'(info_i.subs);
    word[REG_COSITE] = BUS_W'(info_i.cosite);
    word[REG_FCNT]   = BUS_W'(info_i.fcnt);
    word[REG_STATUS] = '0;
    word[REG_STATUS][STAT_BUSY_BIT] = busy_i;
    word[REG_STATUS][STAT_IDLE_BIT] = idle_i;
  end

  // read visibility is fixed by the mode parameters
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_vis
    localparam bit VIS = (i == int'(REG_STATUS)) ||
                         (DEBUG_EN && (!LITE_MODE || lite_field(i)));
    if (VIS) begin : g_on
      assign masked[i] = sel_i[i] ? word[i] : '0;
    end else begin : g_off
      assign masked[i] = '0;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++) rd_word |= masked[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      rdata_q  <= rd_en_i ? rd_word : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_rvalid_follows_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  p_rvalid_drops_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!rvalid_o && rdata_o == '0));
  p_unmapped_zero_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit_i) |=> rdata_o == '0);
  p_status_word_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel_i[REG_STATUS]) |=>
      (rdata_o[STAT_BUSY_BIT] == $past(busy_i) && rdata_o[STAT_IDLE_BIT] == $past(idle_i)
       && rdata_o[1] == 1'b0 && rdata_o[BUS_W-1:3] == '0));

  if (!DEBUG_EN) begin : g_nodbg_chk
    p_write_only_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && !sel_i[REG_STATUS]) |=> rdata_o == '0);
  end
endmodule

// File: rtl/field_info_regs.sv
module field_info_regs
  import field_info_pkg::*;
#(
  parameter bit          LITE_MODE = 1'b1,
  parameter bit          DEBUG_EN  = 1'b1,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  input  logic              pkt_valid_i,
  input  logic [15:0]       pkt_width_m1_i,
  input  logic [15:0]       pkt_height_m1_i,
  input  logic [3:0]        pkt_interlace_i,
  input  logic [6:0]        pkt_colorspace_i,
  input  logic [1:0]        pkt_subsample_i,
  input  logic [1:0]        pkt_cosite_i,
  input  logic [6:0]        pkt_field_count_i,
  input  logic              core_busy_i,
  input  logic              core_idle_i,
  output logic [15:0]       cfg_width_o,
  output logic [15:0]       cfg_height_o,
  output logic [3:0]        cfg_interlace_o,
  output logic [6:0]        cfg_colorspace_o,
  output logic [1:0]        cfg_subsample_o,
  output logic [1:0]        cfg_cosite_o,
  output logic [6:0]        cfg_field_count_o,
  output logic              field_flag_en_o
);
  logic [NUM_REGS-1:0] sel;
  logic                hit;
  field_info_t         pkt;
  field_info_t         info;

  assign pkt = '{width:  pkt_width_m1_i,   height: pkt_height_m1_i,
                 intl:   pkt_interlace_i,  csp:    pkt_colorspace_i,
                 subs:   pkt_subsample_i,  cosite: pkt_cosite_i,
                 fcnt:   pkt_field_count_i};

  field_info_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr_i (addr_i),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  field_info_store #(.LITE_MODE(LITE_MODE)) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .sel_i       (sel),
    .wdata_i     (wdata_i),
    .pkt_valid_i (pkt_valid_i),
    .pkt_i       (pkt),
    .info_o      (info)
  );

  field_info_rdmux #(.LITE_MODE(LITE_MODE), .DEBUG_EN(DEBUG_EN)) i_rdmux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .sel_i    (sel),
    .hit_i    (hit),
    .info_i   (info),
    .busy_i   (core_busy_i),
    .idle_i   (core_idle_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  assign cfg_width_o       = info.width;
  assign cfg_height_o      = info.height;
  assign cfg_interlace_o   = info.intl;
  assign cfg_colorspace_o  = info.csp;
  assign cfg_subsample_o   = info.subs;
  assign cfg_cosite_o      = info.cosite;
  assign cfg_field_count_o = info.fcnt;
  assign field_flag_en_o   = info.intl[FLAG_BIT];

  p_flag_tracks_write_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LITE_MODE && wr_en_i && sel[REG_INTL]) |=> field_flag_en_o == $past(wdata_i[3]));
endmodule

// File: tb/test_field_info_regs.sv
`timescale 1ns/1ps
module test_field_info_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        pkt_valid = 1'b0;
  logic [15:0] p_w = '0, p_h = '0;
  logic [3:0]  p_il = '0;
  logic [6:0]  p_cs = '0, p_fc = '0;
  logic [1:0]  p_ss = '0, p_co = '0;
  logic        busy = 1'b0, idle = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // outputs per instance: 0 lite+debug, 1 lite, 2 full+debug, 3 full
  logic [31:0] rd   [4];
  logic        rv   [4];
  logic [15:0] c_w  [4];
  logic [15:0] c_h  [4];
  logic [3:0]  c_il [4];
  logic [6:0]  c_cs [4];
  logic [1:0]  c_ss [4];
  logic [1:0]  c_co [4];
  logic [6:0]  c_fc [4];
  logic        c_fl [4];

  field_info_regs #(.LITE_MODE(1'b1), .DEBUG_EN(1'b1)) i_field_info_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd[0]), .rvalid_o(rv[0]), .pkt_valid_i(pkt_valid),
    .pkt_width_m1_i(p_w), .pkt_height_m1_i(p_h), .pkt_interlace_i(p_il),
    .pkt_colorspace_i(p_cs), .pkt_subsample_i(p_ss), .pkt_cosite_i(p_co),
    .pkt_field_count_i(p_fc), .core_busy_i(busy), .core_idle_i(idle),
    .cfg_width_o(c_w[0]), .cfg_height_o(c_h[0]), .cfg_interlace_o(c_il[0]),
    .cfg_colorspace_o(c_cs[0]), .cfg_subsample_o(c_ss[0]), .cfg_cosite_o(c_co[0]),
    .cfg_field_count_o(c_fc[0]), .field_flag_en_o(c_fl[0]));

  field_info_regs #(.LITE_MODE(1'b1), .DEBUG_EN(1'b0)) i_field_info_regs_nodbg (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd[1]), .rvalid_o(rv[1]), .pkt_valid_i(pkt_valid),
    .pkt_width_m1_i(p_w), .pkt_height_m1_i(p_h), .pkt_interlace_i(p_il),
    .pkt_colorspace_i(p_cs), .pkt_subsample_i(p_ss), .pkt_cosite_i(p_co),
    .pkt_field_count_i(p_fc), .core_busy_i(busy), .core_idle_i(idle),
    .cfg_width_o(c_w[1]), .cfg_height_o(c_h[1]), .cfg_interlace_o(c_il[1]),
    .cfg_colorspace_o(c_cs[1]), .cfg_subsample_o(c_ss[1]), .cfg_cosite_o(c_co[1]),
    .cfg_field_count_o(c_fc[1]), .field_flag_en_o(c_fl[1]));

  field_info_regs #(.LITE_MODE(1'b0), .DEBUG_EN(1'b1)) i_field_info_regs_full (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd[2]), .rvalid_o(rv[2]), .pkt_valid_i(pkt_valid),
    .pkt_width_m1_i(p_w), .pkt_height_m1_i(p_h), .pkt_interlace_i(p_il),
    .pkt_colorspace_i(p_cs), .pkt_subsample_i(p_ss), .pkt_cosite_i(p_co),
    .pkt_field_count_i(p_fc), .core_busy_i(busy), .core_idle_i(idle),
    .cfg_width_o(c_w[2]), .cfg_height_o(c_h[2]), .cfg_interlace_o(c_il[2]),
    .cfg_colorspace_o(c_cs[2]), .cfg_subsample_o(c_ss[2]), .cfg_cosite_o(c_co[2]),
    .cfg_field_count_o(c_fc[2]), .field_flag_en_o(c_fl[2]));

  field_info_regs #(.LITE_MODE(1'b0), .DEBUG_EN(1'b0)) i_field_info_regs_full_nodbg (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd[3]), .rvalid_o(rv[3]), .pkt_valid_i(pkt_valid),
    .pkt_width_m1_i(p_w), .pkt_height_m1_i(p_h), .pkt_interlace_i(p_il),
    .pkt_colorspace_i(p_cs), .pkt_subsample_i(p_ss), .pkt_cosite_i(p_co),
    .pkt_field_count_i(p_fc), .core_busy_i(busy), .core_idle_i(idle),
    .cfg_width_o(c_w[3]), .cfg_height_o(c_h[3]), .cfg_interlace_o(c_il[3]),
    .cfg_colorspace_o(c_cs[3]), .cfg_subsample_o(c_ss[3]), .cfg_cosite_o(c_co[3]),
    .cfg_field_count_o(c_fc[3]), .field_flag_en_o(c_fl[3]));

  typedef struct packed {
    logic [3:0]  req;
    logic        is_rd;
    logic [11:0] ofs;
    logic [31:0] val;   // write data, or expected read on instance 0
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    {4'd2,  1'b0, 12'h120, 32'hABCD_1280},  // R2 width, upper bits dropped
    {4'd2,  1'b1, 12'h120, 32'h0000_1280},
    {4'd2,  1'b0, 12'h124, 32'h0000_02D0},  // R2 height
    {4'd2,  1'b1, 12'h124, 32'h0000_02D0},
    {4'd3,  1'b0, 12'h128, 32'hFFFF_FFF9},  // R3 interlace nibble
    {4'd3,  1'b1, 12'h128, 32'h0000_0009},
    {4'd3,  1'b0, 12'h138, 32'h0000_0007},  // R3 co-siting
    {4'd3,  1'b1, 12'h138, 32'h0000_0003},
    {4'd4,  1'b0, 12'h130, 32'h0000_0055},  // R4 colour space ignored
    {4'd4,  1'b1, 12'h130, 32'h0000_0000},
    {4'd4,  1'b0, 12'h134, 32'h0000_0003},  // R4 subsampling ignored
    {4'd4,  1'b1, 12'h134, 32'h0000_0000},
    {4'd4,  1'b0, 12'h13C, 32'h0000_007F},  // R4 field count ignored
    {4'd4,  1'b1, 12'h13C, 32'h0000_0000},
    {4'd10, 1'b0, 12'h12C, 32'h0000_FFFF},  // R10 reserved
    {4'd10, 1'b1, 12'h12C, 32'h0000_0000},
    {4'd10, 1'b0, 12'h122, 32'h0000_0001},  // R10 misaligned write ignored
    {4'd10, 1'b1, 12'h120, 32'h0000_1280},
    {4'd10, 1'b1, 12'h122, 32'h0000_0000},
    {4'd10, 1'b1, 12'h200, 32'h0000_0000},
    {4'd2,  1'b1, 12'h124, 32'h0000_02D0}
  };

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send_pkt();
    @(negedge clk);
    pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state on every instance
    for (int k = 0; k < 4; k++) begin
      check("R1", "rdata", rd[k], 32'h0);
      check("R1", "rvalid", {31'h0, rv[k]}, 32'h0);
      check("R1", "width", {16'h0, c_w[k]}, 32'h0);
      check("R1", "flag", {31'h0, c_fl[k]}, 32'h0);
    end
    rst_n = 1'b1;
    do_read(12'h120);
    check("R1", "width read", rd[0], 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].is_rd) begin
        do_read(VECS[i].ofs);
        check($sformatf("R%0d", VECS[i].req), "lite rd", rd[0], VECS[i].val);
        check("R5", "write-only rd", rd[1], 32'h0);  // R5
        check("R11", "rvalid", {31'h0, rv[0]}, 32'h1);
      end else begin
        do_write(VECS[i].ofs, VECS[i].val);
      end
    end

    // R11 one-cycle pulse, data cleared
    @(negedge clk);
    check("R11", "rvalid low", {31'h0, rv[0]}, 32'h0);
    check("R11", "rdata idle", rd[0], 32'h0);

    // R2 / R3 / R4 / R5 configuration outputs
    check("R2", "cfg width", {16'h0, c_w[0]}, 32'h1280);
    check("R2", "cfg height", {16'h0, c_h[0]}, 32'h02D0);
    check("R3", "flag on", {31'h0, c_fl[0]}, 32'h1);
    check("R3", "cfg cosite", {30'h0, c_co[0]}, 32'h3);
    check("R4", "cfg csp", {25'h0, c_cs[0]}, 32'h0);
    check("R4", "cfg fcnt", {25'h0, c_fc[0]}, 32'h0);
    check("R5", "nodbg cfg width", {16'h0, c_w[1]}, 32'h1280);
    check("R5", "nodbg flag", {31'h0, c_fl[1]}, 32'h1);
    do_write(12'h128, 32'h1);
    check("R3", "flag off", {31'h0, c_fl[0]}, 32'h0);

    // R7 bus writes did not land in packet-driven mode
    do_read(12'h120);
    check("R7", "full width", rd[2], 32'h0);
    check("R7", "full cfg il", {28'h0, c_il[2]}, 32'h0);

    // R6 packet capture
    p_w = 16'd1919; p_h = 16'd1079; p_il = 4'hA; p_cs = 7'h45;
    p_ss = 2'd2; p_co = 2'd1; p_fc = 7'h33;
    send_pkt();
    check("R6", "cfg width", {16'h0, c_w[2]}, 32'd1920);
    check("R6", "lite ignores pkt", {16'h0, c_w[0]}, 32'h1280);
    do_read(12'h120); check("R6", "width", rd[2], 32'd1920);
    check("R8", "nodbg width", rd[3], 32'h0);
    do_read(12'h124); check("R6", "height", rd[2], 32'd1080);
    do_read(12'h128); check("R6", "intl", rd[2], 32'hA);
    do_read(12'h130); check("R8", "csp", rd[2], 32'h45);
    check("R8", "nodbg csp", rd[3], 32'h0);
    do_read(12'h134); check("R8", "subs", rd[2], 32'h2);
    do_read(12'h138); check("R8", "cosite", rd[2], 32'h1);
    do_read(12'h13C); check("R8", "fcnt", rd[2], 32'h33);
    check("R8", "nodbg cfg fcnt", {25'h0, c_fc[3]}, 32'h33);
    check("R6", "flag", {31'h0, c_fl[2]}, 32'h1);

    // R12 inputs change without strobe
    p_w = 16'd5; p_fc = 7'h01; p_il = 4'h0;
    repeat (3) @(negedge clk);
    check("R12", "width hold", {16'h0, c_w[2]}, 32'd1920);
    check("R12", "fcnt hold", {25'h0, c_fc[2]}, 32'h33);
    check("R12", "flag hold", {31'h0, c_fl[2]}, 32'h1);

    // R6 wrap of width at 0xFFFF
    p_w = 16'hFFFF;
    send_pkt();
    do_read(12'h120); check("R6", "width wrap", rd[2], 32'h0);
    check("R6", "intl recapture", {28'h0, c_il[2]}, 32'h0);

    // R9 status on every instance
    busy = 1'b1; idle = 1'b0;
    do_read(12'h140);
    for (int k = 0; k < 4; k++) check("R9", "status busy", rd[k], 32'h1);
    busy = 1'b0; idle = 1'b1;
    do_read(12'h140);
    for (int k = 0; k < 4; k++) check("R9", "status idle", rd[k], 32'h4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule